// File: doc/BRIEF.md
# Query Report Writer

This block turns a single write of the query-get command word into a memory write of a query report. The command word carries four fields: unit, select, mode and a short-format flag. When the decoded combination is supported, the block captures the programmed report address, the current query sequence and the value of a free-running tick counter. It then emits the report on a beat-based memory write port that carries an address, a 64-bit data word and a byte count. Combinations it does not support raise a one-cycle error pulse and write nothing.

The short format writes one 32-bit word holding the sequence. The long format writes a 16-byte record as two 64-bit beats: the report value at the report address, then the timestamp at the address plus 8. Both beats are little-endian, so the low byte of each field sits at the lowest address. For the only supported select, the report value is the sequence, zero-extended to 64 bits. While a report is in flight the block is busy and ignores further command writes.

The control is a four-state machine. In IDLE nothing is sent and a command write can be accepted. ONE_WORD drives the single short beat. VALUE_BEAT drives the first long beat and STAMP_BEAT drives the second. The transitions are as follows. IDLE goes to ONE_WORD when a supported short command is accepted and to VALUE_BEAT when a supported long command is accepted. It stays in IDLE on an unsupported command. ONE_WORD goes back to IDLE when its beat is accepted. VALUE_BEAT goes to STAMP_BEAT when its beat is accepted, and STAMP_BEAT goes to IDLE when its beat is accepted. In every beat state the machine holds while `mem_ready` is low.

Top module: `qrw_report_writer`

## Requirements
- R1: After reset, `mem_valid`, `busy` and `err` are all low.
- R2: A command is accepted only in a cycle where `get_wr` is high and `busy` is low. A `get_wr` pulse while `busy` is high is ignored: it raises no error and does not change the report in flight.
- R3: The unit field is `get_word[15:12]`, and only the value 15 (the crop unit) is supported. Any other unit gives `err` high for exactly the one cycle after acceptance, and no beat is issued.
- R4: The select field is `get_word[20:16]`, and only the value 0 (zero select) is supported. Any other select gives the same error pulse and issues no beat.
- R5: The mode field is `get_word[1:0]`. The values 0 and 1 are both write modes. The values 2 and 3 give the error pulse and issue no beat.
- R6: When `get_word[28]` is 1 (short format), exactly one beat is issued. Its address is the captured report address, its data is the sequence in bits 31:0 with zeros above, and `mem_bytes` is 4.
- R7: When `get_word[28]` is 0 (long format), two beats are issued with `mem_bytes` of 8. The first carries the zero-extended sequence at the report address. The second carries the timestamp at the report address plus 8.
- R8: The timestamp equals the tick counter value in the cycle the command is accepted. The counter is 0 in the first cycle after reset and advances by one every cycle.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_data` and `mem_bytes` hold their values.
- R10: The report address and the sequence are captured at acceptance. Changes to `query_addr` or `query_seq` while busy do not alter the beats.
- R11: The tick counter wraps modulo 2^TS_W, and the timestamp is zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| get_wr | input | 1 | Command word write strobe |
| get_word | input | 32 | Command word: mode, unit, select, short flag |
| query_addr | input | ADDR_W | Programmed report address |
| query_seq | input | SEQ_W | Current query sequence value |
| busy | output | 1 | Report in flight; new commands ignored |
| err | output | 1 | One-cycle pulse for an unsupported command |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory write beat accepted |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_data | output | 64 | Little-endian beat data |
| mem_bytes | output | 4 | Number of valid bytes in the beat (4 or 8) |

## Verification
The bench builds the block with ADDR_W of 40, SEQ_W of 32 and TS_W of 12. With a 12-bit tick counter, the wrap to zero happens after 4096 cycles, so a run of a few thousand cycles can observe a timestamp taken at the all-ones counter value and another taken after the wrap. A 40-bit address lets the second long beat be placed at a report address whose addition of 8 carries across byte and word boundaries, which checks the address step rather than a bit-set.

// File: rtl/qrw_pkg.sv
package qrw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ONE_WORD = 2'd1,
        ST_VALUE    = 2'd2,
        ST_STAMP    = 2'd3
    } qrw_state_e;

    // command word field positions
    localparam int MODE_LSB   = 0;
    localparam int MODE_W     = 2;
    localparam int UNIT_LSB   = 12;
    localparam int UNIT_W     = 4;
    localparam int SEL_LSB    = 16;
    localparam int SEL_W      = 5;
    localparam int SHORT_BIT  = 28;

    localparam logic [MODE_W-1:0] MODE_WRITE_A = 2'd0;
    localparam logic [MODE_W-1:0] MODE_WRITE_B = 2'd1;
    localparam logic [SEL_W-1:0]  SEL_ZERO     = 5'd0;

    localparam int DATA_W = 64;

    typedef struct packed {
        logic unit_ok;
        logic sel_ok;
        logic mode_ok;
        logic short_fmt;
    } qrw_decode_t;

endpackage

// File: rtl/qrw_tick_counter.sv
module qrw_tick_counter #(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] tick
);

    logic run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick  <= '0;
            run_q <= 1'b0;
        end else begin
            tick  <= tick + TS_W'(1);
            run_q <= 1'b1;
        end
    end

    // R8 / R11: the counter advances by one each cycle, wrapping modulo 2^TS_W
    p_tick_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> tick == $past(tick) + TS_W'(1));

endmodule

// File: rtl/qrw_field_decode.sv
module qrw_field_decode
    import qrw_pkg::*;
#(
    parameter logic [UNIT_W-1:0] CROP_UNIT = 4'hF
) (
    input  logic [31:0]  word,
    output qrw_decode_t  dec
);

    logic [MODE_W-1:0] mode_f;
    logic [UNIT_W-1:0] unit_f;
    logic [SEL_W-1:0]  sel_f;

    always_comb begin
        mode_f        = word[MODE_LSB +: MODE_W];
        unit_f        = word[UNIT_LSB +: UNIT_W];
        sel_f         = word[SEL_LSB +: SEL_W];
        dec.unit_ok   = (unit_f == CROP_UNIT);
        dec.sel_ok    = (sel_f == SEL_ZERO);
        dec.mode_ok   = (mode_f == MODE_WRITE_A) || (mode_f == MODE_WRITE_B);
        dec.short_fmt = word[SHORT_BIT];
    end

endmodule

// File: rtl/qrw_beat_fsm.sv
module qrw_beat_fsm
    import qrw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_short,
    input  logic       start_long,
    input  logic       beat_ready,
    output qrw_state_e state_q,
    output logic       busy,
    output logic       beat_valid
);

    qrw_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_short)     state_d = ST_ONE_WORD;
                else if (start_long) state_d = ST_VALUE;
            end
            ST_ONE_WORD: if (beat_ready) state_d = ST_IDLE;
            ST_VALUE:    if (beat_ready) state_d = ST_STAMP;
            ST_STAMP:    if (beat_ready) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b1;
        beat_valid = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy       = 1'b0;
                beat_valid = 1'b0;
            end
            ST_ONE_WORD, ST_VALUE, ST_STAMP: begin
                busy       = 1'b1;
                beat_valid = 1'b1;
            end
            default: begin
                busy       = 1'b0;
                beat_valid = 1'b0;
            end
        endcase
    end

    // R6: a short report ends after its only beat
    p_short_single_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONE_WORD && beat_ready) |=> !beat_valid);

endmodule

// File: rtl/qrw_report_writer.sv
module qrw_report_writer
    import qrw_pkg::*;
#(
    parameter int                ADDR_W    = 48,
    parameter int                SEQ_W     = 32,
    parameter int                TS_W      = 64,
    parameter logic [UNIT_W-1:0] CROP_UNIT = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              get_wr,
    input  logic [31:0]       get_word,
    input  logic [ADDR_W-1:0] query_addr,
    input  logic [SEQ_W-1:0]  query_seq,
    output logic              busy,
    output logic              err,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [3:0]        mem_bytes
);

    localparam logic [ADDR_W-1:0] STAMP_OFS  = ADDR_W'(8);
    localparam logic [3:0]        BYTES_WORD = 4'd4;
    localparam logic [3:0]        BYTES_LONG = 4'd8;

    qrw_decode_t       dec;
    qrw_state_e        state_q;
    logic [TS_W-1:0]   tick;
    logic              accept;
    logic              cmd_ok;
    logic              start_short;
    logic              start_long;
    logic [ADDR_W-1:0] lat_addr;
    logic [SEQ_W-1:0]  lat_seq;
    logic [TS_W-1:0]   lat_stamp;
    logic              err_q;

    qrw_tick_counter #(.TS_W(TS_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    qrw_field_decode #(.CROP_UNIT(CROP_UNIT)) u_dec (
        .word (get_word),
        .dec  (dec)
    );

    assign accept      = get_wr && !busy;
    assign cmd_ok      = dec.unit_ok && dec.sel_ok && dec.mode_ok;
    assign start_short = accept && cmd_ok && dec.short_fmt;
    assign start_long  = accept && cmd_ok && !dec.short_fmt;

    qrw_beat_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_short (start_short),
        .start_long  (start_long),
        .beat_ready  (mem_ready),
        .state_q     (state_q),
        .busy        (busy),
        .beat_valid  (mem_valid)
    );

    // capture of report operands at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_seq   <= '0;
            lat_stamp <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= accept && !cmd_ok;
            if (accept && cmd_ok) begin
                lat_addr  <= query_addr;
                lat_seq   <= query_seq;
                lat_stamp <= tick;
            end
        end
    end

    assign err = err_q;

    // beat contents per state
    always_comb begin
        mem_addr  = lat_addr;
        mem_data  = '0;
        mem_bytes = BYTES_LONG;
        unique case (state_q)
            ST_IDLE: begin
                mem_addr  = lat_addr;
                mem_data  = '0;
                mem_bytes = BYTES_LONG;
            end
            ST_ONE_WORD: begin
                mem_data  = DATA_W'(lat_seq[SEQ_W-1:0]);
                mem_bytes = BYTES_WORD;
            end
            ST_VALUE: begin
                mem_data  = DATA_W'(lat_seq);
                mem_bytes = BYTES_LONG;
            end
            ST_STAMP: begin
                mem_addr  = lat_addr + STAMP_OFS;
                mem_data  = DATA_W'(lat_stamp);
                mem_bytes = BYTES_LONG;
            end
            default: begin
                mem_addr  = lat_addr;
                mem_data  = '0;
                mem_bytes = BYTES_LONG;
            end
        endcase
    end

    // R3 / R4 / R5: an unsupported command produces no beat
    p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_valid);

    // R9: a stalled beat keeps all of its fields
    p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
            && $stable(mem_data) && $stable(mem_bytes)));

    // R7: the timestamp beat follows the value beat, eight bytes higher
    p_stamp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && state_q == ST_VALUE) |=>
            (mem_valid && mem_addr == $past(mem_addr) + STAMP_OFS));

    // R2: no beat fields change because of a command seen while busy
    p_busy_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && get_wr && !mem_ready) |=> $stable(mem_data));

endmodule

// File: tb/qrw_report_writer_bench.sv
module qrw_report_writer_bench;

    localparam int ADDR_W = 40;
    localparam int SEQ_W  = 32;
    localparam int TS_W   = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              get_wr = 1'b0;
    logic [31:0]       get_word = '0;
    logic [ADDR_W-1:0] query_addr = '0;
    logic [SEQ_W-1:0]  query_seq = '0;
    logic              busy, err, mem_valid;
    logic              mem_ready = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic [63:0]       mem_data;
    logic [3:0]        mem_bytes;

    int checks = 0;
    int fails  = 0;
    logic [TS_W-1:0] tb_ticks;
    logic [TS_W-1:0] exp_stamp;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    qrw_report_writer #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .TS_W(TS_W)) u_qrw_report_writer (
        .clk(clk), .rst_n(rst_n), .get_wr(get_wr), .get_word(get_word),
        .query_addr(query_addr), .query_seq(query_seq), .busy(busy), .err(err),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_bytes(mem_bytes)
    );

    // reference tick: 0 in first cycle after reset, +1 per cycle
    always @(posedge clk) begin
        if (!rst_n) tb_ticks <= '0;
        else        tb_ticks <= tb_ticks + 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] unit, input logic [4:0] sel,
                                       input logic [1:0] mode, input logic shrt);
        logic [31:0] w = '0;
        w[1:0]   = mode;
        w[15:12] = unit;
        w[20:16] = sel;
        w[28]    = shrt;
        return w;
    endfunction

    // drive a command for one cycle; returns at the negedge after acceptance
    task automatic send(input logic [31:0] w);
        get_wr    = 1'b1;
        get_word  = w;
        exp_stamp = tb_ticks;
        @(posedge clk);
        @(negedge clk);
        get_wr = 1'b0;
    endtask

    task automatic beat(input logic [ADDR_W-1:0] a, input logic [63:0] d, input logic [3:0] b, input string tag);
        chk(mem_valid == 1'b1, {tag, " valid"}, 64'(mem_valid), 64'd1);
        chk(mem_addr == a, {tag, " addr"}, 64'(mem_addr), 64'(a));
        chk(mem_data == d, {tag, " data"}, mem_data, d);
        chk(mem_bytes == b, {tag, " bytes"}, 64'(mem_bytes), 64'(b));
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(!mem_valid, "R1 valid", 64'(mem_valid), 64'd0);
        chk(!busy, "R1 busy", 64'(busy), 64'd0);
        chk(!err, "R1 err", 64'(err), 64'd0);
    endtask

    task automatic t_short;
        query_addr = 40'h12_3456_7890;
        query_seq  = 32'hCAFE_0001;
        send(mk(4'hF, 5'd0, 2'd1, 1'b1));
        beat(40'h12_3456_7890, 64'h0000_0000_CAFE_0001, 4'd4, "R6 short");
        chk(!mem_valid && !busy, "R6 single beat", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_long(input logic [1:0] mode, input logic [ADDR_W-1:0] a, input logic [31:0] s);
        query_addr = a;
        query_seq  = s;
        send(mk(4'hF, 5'd0, mode, 1'b0));
        beat(a, 64'(s), 4'd8, "R7 value");
        beat(a + 40'd8, 64'(exp_stamp), 4'd8, "R8 stamp");
        chk(!mem_valid, "R7 two beats", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_err(input logic [31:0] w, input string tag);
        send(w);
        chk(err == 1'b1, {tag, " err"}, 64'(err), 64'd1);
        chk(!mem_valid && !busy, {tag, " no write"}, 64'(mem_valid), 64'd0);
        @(negedge clk);
        chk(!err && !mem_valid, {tag, " pulse"}, 64'(err), 64'd0);
    endtask

    task automatic t_stall;
        logic [TS_W-1:0] st;
        query_addr = 40'h00_0000_FFF8;
        query_seq  = 32'h0000_0777;
        mem_ready  = 1'b0;
        send(mk(4'hF, 5'd0, 2'd0, 1'b0));
        st = exp_stamp;
        query_addr = 40'hAA_AAAA_AAAA;
        query_seq  = 32'h5555_5555;
        for (int i = 0; i < 4; i++) begin
            chk(mem_valid && mem_addr == 40'h00_0000_FFF8 && mem_data == 64'h777,
                "R9 stall hold", mem_data, 64'h777);
            if (i == 1) begin
                get_wr   = 1'b1;
                get_word = mk(4'h3, 5'd0, 2'd0, 1'b1);
            end
            @(negedge clk);
            get_wr = 1'b0;
        end
        chk(!err, "R2 ignored while busy", 64'(err), 64'd0);
        mem_ready = 1'b1;
        beat(40'h00_0000_FFF8, 64'h777, 4'd8, "R10 captured value");
        beat(40'h00_0001_0000, 64'(st), 4'd8, "R8 stamp under stall");
        chk(!mem_valid && !err, "R2 no extra report", 64'(mem_valid), 64'd0);
    endtask

    task automatic t_wrap;
        while (tb_ticks != {TS_W{1'b1}}) @(negedge clk);
        t_long(2'd1, 40'h01_0000_0000, 32'hFFFF_FFFF);
        chk(exp_stamp == {TS_W{1'b1}}, "R11 max stamp", 64'(exp_stamp), 64'hFFF);
        while (tb_ticks != TS_W'(3)) @(negedge clk);
        t_long(2'd0, 40'h01_0000_0100, 32'h1);
        chk(exp_stamp == TS_W'(3), "R11 wrapped stamp", 64'(exp_stamp), 64'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_short();
        t_long(2'd0, 40'h00_0000_1000, 32'h0000_0042);
        t_long(2'd1, 40'h7F_FFFF_FFF0, 32'h8000_0000);
        t_err(mk(4'h2, 5'd0, 2'd0, 1'b1), "R3 unit");
        t_err(mk(4'hF, 5'd1, 2'd0, 1'b0), "R4 select");
        t_err(mk(4'hF, 5'd0, 2'd2, 1'b1), "R5 mode2");
        t_err(mk(4'hF, 5'd0, 2'd3, 1'b0), "R5 mode3");
        t_stall();
        t_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule